// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the target side of a two-wire serial byte memory. It watches the clock and data lines of the bus, which it samples into the system clock domain. It pulls the data line low through an open-drain enable, and it holds the storage array itself as a register array that block RAM can implement. A controller addresses the block with a fixed 4-bit prefix and three strap bits. It then sets an internal byte pointer with two address bytes, and either writes data bytes or turns the transfer around with a repeated START to read.

The pointer advances in two different ways. While the block takes in data it counts only within the current 64-byte page, so the page's upper address bits stay fixed. While it sends data it counts through the whole array and rolls over from the last location to zero. A read that has no address phase starts at whatever the pointer held after the previous transfer. A write-protect input blocks storage but still lets every byte be acknowledged. After a STOP that follows a stored byte, a busy window opens, and during it the block will not answer its own address.

Top module: `twi_mem_target`

## Requirements
- R1: The block acknowledges a bus address byte whose upper seven bits equal binary 1010 followed by `strap[2:0]`. Bit 0 of that byte selects the direction: 1 means read, 0 means write. On any other address it leaves the data line released, and it ignores every later byte until the next START.
- R2: START is the data line falling while the clock line is high, and STOP is the data line rising while the clock line is high. After STOP the block is idle and `sda_oe` is 0; after reset `sda_oe` and `busy` are 0.
- R3: The first address byte supplies pointer bits 13..8 in its bits 5..0, and its bits 7..6 are ignored. The second address byte supplies bits 7..0. Pointer bits at or above `MEM_AW` are dropped, so the array has 2**`MEM_AW` bytes.
- R4: In a write, every data byte is acknowledged and stored at the pointer, and the pointer then advances.
- R5: While the block takes in data, the pointer advances in its low 6 bits only. It wraps from the last byte of a 64-byte page to the first byte of the same page.
- R6: An address byte with the read bit set and no address phase before it returns the byte at the current pointer.
- R7: A write address byte, then two address bytes, then a repeated START and a read address byte returns the byte at the address just sent, and nothing is stored.
- R8: A controller ACK after a returned byte makes the block send the next byte. The pointer advances over the whole array and wraps from the last location to 0. A NACK followed by STOP ends the read.
- R9: While `wp_in` is 1, data bytes are acknowledged but not stored, and no busy window opens.
- R10: A STOP that ends a transfer in which at least one byte was stored raises `busy` for `BUSY_CYCLES` clocks. While `busy` is 1, the block does not acknowledge its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| wp_in | input | 1 | Write protect, 1 blocks storage |
| strap | input | 3 | Low three bits of the bus address |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Internal write window active |

## Verification
Two of the block's functions can land in one cycle. In a dummy write, the state that waits for a data byte can see a repeated START instead. The bench provokes this with a chosen-address read. It then judges, byte by byte, that the reply comes from the new address and that the location still holds its old value. The second overlap is an address poll that arrives while the busy window is still counting: the bench sends the block's own address right after the STOP of a write and expects a NACK. The same address, sent once the window has run out, must be acknowledged.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
  } st_t;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         FULL_AW    = 14;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic lvl,
  output logic prv
);
  logic [STAGES:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], d_in};
  end
  assign lvl = sh[STAGES-1];
  assign prv = sh[STAGES];
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int AW = 11,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_lin,
  output logic [AW-1:0] ctr
);
  always_ff @(posedge clk) begin
    if (rst)           ctr <= '0;
    else if (load)     ctr <= load_val;
    else if (inc_page) ctr <= {ctr[AW-1:PW], ctr[PW-1:0] + PW'(1)};
    else if (inc_lin)  ctr <= ctr + AW'(1);
  end

  // R5
  page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_page && !load) |=> (ctr[AW-1:PW] == $past(ctr[AW-1:PW])));

  // R8
  arr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_lin && !inc_page && !load && (&ctr)) |=> (ctr == '0));
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target import twi_mem_pkg::*; #(
  parameter int MEM_AW      = 11,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYCLES = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       wp_in,
  input  logic [2:0] strap,
  output logic       sda_oe,
  output logic       busy
);
  localparam int HI_KEEP = MEM_AW - 8;
  localparam int BCW     = $clog2(BUSY_CYCLES + 1);

  logic [1:0] ln_in, ln_lvl, ln_prv;
  assign ln_in = {sda_in, scl_in};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_in(ln_in[g]), .lvl(ln_lvl[g]), .prv(ln_prv[g]));
  end

  logic scl_l, scl_p, sda_l, sda_p;
  assign scl_l = ln_lvl[0];
  assign scl_p = ln_prv[0];
  assign sda_l = ln_lvl[1];
  assign sda_p = ln_prv[1];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_l & ~scl_p;
  assign scl_fall = ~scl_l & scl_p;
  assign start_c  = scl_l & scl_p & sda_p & ~sda_l;
  assign stop_c   = scl_l & scl_p & ~sda_p & sda_l;

  logic [1:0] wp_sh;
  logic       wp_s;
  always_ff @(posedge clk) begin
    if (rst) wp_sh <= '0;
    else     wp_sh <= {wp_sh[0], wp_in};
  end
  assign wp_s = wp_sh[1];

  st_t               st;
  logic [3:0]        bcnt;
  logic [7:0]        shr;
  logic [HI_KEEP-1:0] ahi;
  logic              rw, mack, wrote, oe_r;
  logic [BCW-1:0]    busy_cnt;
  logic [MEM_AW-1:0] ptr;
  logic [7:0]        rdata;

  logic byte_done, ctr_load, inc_page, inc_lin, mem_we;
  always_comb begin
    byte_done = scl_fall && (bcnt == 4'd8);
    ctr_load  = (st == ST_ALO) && byte_done;
    inc_page  = (st == ST_WDAT) && byte_done;
    mem_we    = inc_page && !wp_s;
    inc_lin   = (st == ST_RACK) && scl_rise;
  end

  twi_addr_ctr #(.AW(MEM_AW), .PW(PAGE_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_val({ahi, shr}),
    .inc_page(inc_page), .inc_lin(inc_lin), .ctr(ptr));

  twi_mem_array #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(shr), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bcnt <= '0; shr <= '0; ahi <= '0; rw <= 1'b0;
      mack <= 1'b0; wrote <= 1'b0; oe_r <= 1'b0; busy_cnt <= '0;
    end else begin
      if (stop_c && wrote)    busy_cnt <= BCW'(BUSY_CYCLES);
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - BCW'(1);

      if (start_c) begin
        st <= ST_DEV; bcnt <= '0; oe_r <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; oe_r <= 1'b0; wrote <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise && bcnt < 4'd8) begin
              shr  <= {shr[6:0], sda_l};
              bcnt <= bcnt + 4'd1;
            end
            if (byte_done) begin
              case (st)
                ST_DEV: begin
                  if (shr[7:1] == {DEV_PREFIX, strap} && busy_cnt == 0) begin
                    oe_r <= 1'b1; rw <= shr[0]; st <= ST_DEV_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_AHI: begin
                  ahi <= shr[HI_KEEP-1:0]; oe_r <= 1'b1; st <= ST_AHI_ACK;
                end
                ST_ALO: begin
                  oe_r <= 1'b1; st <= ST_ALO_ACK;
                end
                default: begin
                  oe_r <= 1'b1; st <= ST_WDAT_ACK;
                  if (!wp_s) wrote <= 1'b1;
                end
              endcase
            end
          end
          ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              oe_r <= 1'b0; bcnt <= '0;
              case (st)
                ST_DEV_ACK: begin
                  if (rw) begin
                    st <= ST_RDAT; shr <= rdata; oe_r <= ~rdata[7];
                  end else begin
                    st <= ST_AHI;
                  end
                end
                ST_AHI_ACK: st <= ST_ALO;
                default:    st <= ST_WDAT;
              endcase
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                oe_r <= 1'b0; st <= ST_RACK;
              end else begin
                shr  <= {shr[6:0], 1'b0};
                oe_r <= ~shr[6];
                bcnt <= bcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_l;
            if (scl_fall) begin
              bcnt <= '0;
              if (mack) begin
                st <= ST_RDAT; shr <= rdata; oe_r <= ~rdata[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = oe_r;
  assign busy   = (busy_cnt != 0);

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);

  // R10
  busy_noack_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st != ST_DEV_ACK));

  // R1
  dev_ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEV_ACK) |-> sda_oe);

  // R9
  wp_noclaim_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDAT && byte_done && wp_s && !wrote) |=> !wrote);
endmodule

// File: tb/tb_twi_mem_target.sv
module tb_twi_mem_target;
  localparam int CLK_P  = 10;
  localparam int BUSY_N = 400;
  localparam int AW     = 11;
  localparam int DEPTH  = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, busy, sda_line;
  int total = 0, bad = 0;
  bit quiet = 1'b0;

  logic [7:0] mdl [DEPTH];
  int mptr = 0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_mem_target #(.MEM_AW(AW), .PAGE_W(6), .BUSY_CYCLES(BUSY_N)) dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .wp_in(wp),
    .strap(STRAP), .sda_oe(sda_oe), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // every clock: the target must keep the line free while the controller drives a bit
  always @(negedge clk) begin
    if (quiet && !rst) begin
      total++;
      if (sda_oe) begin
        bad++;
        $display("FAIL R2 target drove during controller bit act=1 exp=0");
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(4); scl = 1'b1; tick(1); quiet = 1'b1; tick(6);
    quiet = 1'b0; tick(1); scl = 1'b0; tick(4);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); b = sda_line; tick(4);
    scl = 1'b0; tick(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); sda_m = 1'b0; tick(4);
    scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4); scl = 1'b1; tick(4); sda_m = 1'b1; tick(8);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
    send_bit(!mack);
  endtask

  task automatic addr_phase(input int a);
    bit ack;
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b0}, ack); chk(ack, "R1 own address ack", ack, 1);
    wr_byte({2'b10, 6'(a >> 8)}, ack);    chk(ack, "R3 high address ack", ack, 1);
    wr_byte(8'(a), ack);                  chk(ack, "R3 low address ack", ack, 1);
    mptr = a % DEPTH;
  endtask

  task automatic do_write(input int a, input int n, input logic [7:0] base);
    bit ack;
    addr_phase(a);
    for (int k = 0; k < n; k++) begin
      wr_byte(base + 8'(k), ack);
      chk(ack, "R4 data byte ack", ack, 1);
      if (!wp) mdl[mptr] = base + 8'(k);
      mptr = (mptr & ~63) | ((mptr + 1) & 63);
    end
    bus_stop();
  endtask

  task automatic do_read(input int a, input int n, input string tag);
    bit ack;
    logic [7:0] v;
    if (a >= 0) addr_phase(a);
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k < n - 1, v);
      chk(v === mdl[mptr], tag, v, mdl[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
  endtask

  task automatic wait_busy();
    tick(BUSY_N + 60);
    chk(busy == 1'b0, "R10 busy window ends", busy, 0);
  endtask

  initial begin
    bit ack;
    tick(5); rst = 1'b0; tick(5);
    chk(sda_oe == 1'b0, "R2 reset sda_oe", sda_oe, 0);
    chk(busy == 1'b0, "R2 reset busy", busy, 0);

    // R1: wrong strap, then own address without a new START
    bus_start();
    wr_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, ack);
    chk(!ack, "R1 foreign address nack", ack, 0);
    wr_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(!ack, "R1 ignored until START", ack, 0);
    bus_stop();

    // R3/R4: address above the array folds down; R10 poll during busy
    do_write(14'h2105, 1, 8'h5A);
    chk(busy == 1'b1, "R10 busy after stored write", busy, 1);
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(!ack, "R10 no ack while busy", ack, 0);
    bus_stop();
    wait_busy();
    bus_start();
    wr_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(ack, "R10 ack after busy", ack, 1);
    bus_stop();

    do_write(14'h0100, 1, 8'h77); wait_busy();
    // R5: page write crossing the page end
    do_write(14'h00FC, 8, 8'h10); wait_busy();
    // R7/R8: chosen address, sequential across a page boundary
    do_read(14'h00FE, 3, "R7 R8 chosen address sequential");
    // R5: wrapped bytes at page start, R6 current address read
    do_read(14'h00C0, 3, "R5 page wrap readback");
    do_read(-1, 1, "R6 current address read");
    do_read(14'h0105, 1, "R3 R7 folded address readback");

    // R8: array end wrap
    do_write(14'h07FF, 1, 8'hA1); wait_busy();
    do_write(14'h0000, 1, 8'hB2); wait_busy();
    do_read(14'h07FF, 2, "R8 array end wrap");

    // R9: protected write acked, not stored, no busy
    wp = 1'b1; tick(4);
    do_write(14'h0105, 1, 8'h33);
    chk(busy == 1'b0, "R9 no busy when protected", busy, 0);
    wp = 1'b0; tick(4);
    do_read(14'h0105, 1, "R9 protected location unchanged");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule